// File: doc/BRIEF.md
# Deep Sleep Power Sequencer

This block takes the core power rail and the system oscillator into and out of a deep sleep state. It drives two request pins to the outside: a core power request and a system clock request. Each pin has its own programmable polarity. The clock request pin also has a separate output enable. A short register write port loads the control bits, the stabilisation counts and the minimum off time, and it accepts a sleep command.

After a sleep command the block drops both requests. It then stays asleep for at least the programmed off time, even when a wake event comes in early. An early wake is remembered and served as soon as the off time has run out. On exit the block raises the requests again and waits for the rail to settle, counted on a fast tick. It then waits for the oscillator to settle, counted on a tick four times slower. At the end it gives a one-cycle ready pulse.

Both ticks come from a free-running internal prescaler. With the default parameters the fast tick fires every 4 clock cycles and the slow tick every 16.

Top module: `deep_sleep_seq`

## Requirements
- R1: After reset the core request pin is at its active level (high, because the control register resets to 0), the clock request pin is 0, the clock request output enable is 0 and ready is 0.
- R2: Control register (address 0) bit 0 sets the core request polarity: 0 means active high, 1 means active low. The pin shows the active level while awake and the inactive level while asleep.
- R3: Control register bit 1 sets the clock request polarity with the same meaning as bit 0. Bit 2 is the clock request output enable and drives the output enable pin directly. While bit 2 is 0 the clock request pin is held at 0.
- R4: Writing data bit 0 = 1 to address 3 while awake puts the block to sleep. The requests go inactive in the cycle after the write edge.
- R5: Once asleep, the block stays asleep while the off timer (address 2, in fast ticks) counts down. This means at least (N-1)*P+1 clock cycles and at most N*P+2, where P is the fast tick period. A wake event during this time does not end sleep early.
- R6: A wake that arrives during the off time is latched, and exit starts on the first cycle after expiry. Without a wake the block stays asleep indefinitely until one arrives, and exit starts in the cycle after that wake.
- R7: The power-good register (address 1) holds the rail count in bits [7:0], in fast ticks, and the oscillator count in bits [15:8], in slow ticks of period 4*P. The oscillator wait starts only after the rail wait has finished. Ready follows the request re-assertion after between (R-1)*P+(O-1)*4P and R*P+4*O*P+3 cycles.
- R8: Ready is a single-cycle pulse, issued on the return to the awake state.
- R9: A power-good write with either field equal to zero is ignored. An off timer write of zero is ignored. In both cases the previous or default value is kept.
- R10: A sleep command while the block is not awake is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 ctrl, 1 power-good, 2 off time, 3 command) |
| regData | input | 16 | Register write data |
| wakeEvt | input | 1 | Wake event, sampled each cycle |
| coreReq | output | 1 | Core power request pin |
| clkReq | output | 1 | System clock request pin |
| clkReqOe | output | 1 | Clock request output enable |
| ready | output | 1 | One-cycle pulse when exit is complete |

## Verification
Sleep and wake cycles are driven with random off times and random stabilisation counts from a fixed seed. Some cycles wake early, which shows the minimum off time overriding the wake and the latched wake being served. Other cycles wake late, which shows that the block waits for a wake and that exit begins at once after it. The measured off and exit durations are compared with windows computed from the counts. These windows separate correct chaining of the two stabilisation waits from merged, swapped or skipped waits. Directed cases cover both polarity settings, a gated clock request, zero-valued timer writes against prior values, and a sleep command issued during exit.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int FLD_W = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_GOOD = 2'd1;
  localparam logic [1:0] ADDR_OFF  = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_OFF_HOLD  = 3'd1,
    ST_OFF_WAIT  = 3'd2,
    ST_RAIL_WAIT = 3'd3,
    ST_OSC_WAIT  = 3'd4
  } seqState_t;

  typedef struct packed {
    logic loadOff;
    logic loadRail;
    logic loadOsc;
    logic countFast;
    logic countSlow;
  } seqStrobe_t;
endpackage

// File: rtl/dss_tick.sv
module dss_tick #(
  parameter int PRESCALE = 4,
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  output logic fastTick,
  output logic slowTick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SLOW_DIV - 1);

  logic [PW-1:0] preCnt;
  logic [SW-1:0] slowCnt;

  assign fastTick = (preCnt == P_LAST);
  assign slowTick = fastTick && (slowCnt == S_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      slowCnt <= '0;
    end else begin
      preCnt <= fastTick ? '0 : preCnt + 1'b1;
      if (fastTick) slowCnt <= (slowCnt == S_LAST) ? '0 : slowCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dss_dpath.sv
module dss_dpath
  import dss_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int OFF_W     = 16,
  parameter int RAIL_DEF  = 4,
  parameter int OSC_DEF   = 2,
  parameter int OFF_DEF   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regData,
  input  seqStrobe_t        stb,
  input  logic              fastTick,
  input  logic              slowTick,
  input  logic              reqActive,
  output logic              sleepCmd,
  output logic              tmrZero,
  output logic              coreReqPin,
  output logic              clkReqPin,
  output logic              clkReqOe
);
  logic [2:0]       ctrlReg;
  logic [FLD_W-1:0] railCnt, oscCnt;
  logic [OFF_W-1:0] offTime, tmrCnt;
  logic [FLD_W-1:0] newRail, newOsc;
  logic             tickHit;

  assign newRail  = regData[FLD_W-1:0];
  assign newOsc   = regData[2*FLD_W-1:FLD_W];
  assign sleepCmd = regWe && (regAddr == ADDR_CMD) && regData[0];
  assign tmrZero  = (tmrCnt == '0);
  assign tickHit  = (stb.countFast && fastTick) || (stb.countSlow && slowTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      railCnt <= FLD_W'(RAIL_DEF);
      oscCnt  <= FLD_W'(OSC_DEF);
      offTime <= OFF_W'(OFF_DEF);
    end else if (regWe) begin
      case (regAddr)
        ADDR_CTRL: ctrlReg <= regData[2:0];
        ADDR_GOOD: if (newRail != '0 && newOsc != '0) begin
          railCnt <= newRail;
          oscCnt  <= newOsc;
        end
        ADDR_OFF: if (regData[OFF_W-1:0] != '0) offTime <= regData[OFF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       tmrCnt <= '0;
    else if (stb.loadOff)            tmrCnt <= offTime;
    else if (stb.loadRail)           tmrCnt <= OFF_W'(railCnt);
    else if (stb.loadOsc)            tmrCnt <= OFF_W'(oscCnt);
    else if (tickHit && !tmrZero)    tmrCnt <= tmrCnt - 1'b1;
  end

  assign coreReqPin = reqActive ^ ctrlReg[0];
  assign clkReqOe   = ctrlReg[2];
  assign clkReqPin  = ctrlReg[2] ? (reqActive ^ ctrlReg[1]) : 1'b0;

  a_r9_off_zero_keep: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_OFF && regData[OFF_W-1:0] == '0) |=> $stable(offTime));
  a_r9_good_zero_keep: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_GOOD && (newRail == '0 || newOsc == '0))
      |=> ($stable(railCnt) && $stable(oscCnt)));
  a_r3_gated_low: assert property (@(posedge clk) disable iff (!rstN)
    !clkReqOe |-> !clkReqPin);
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepCmd,
  input  logic       wakeEvt,
  input  logic       tmrZero,
  output seqStrobe_t stb,
  output logic       reqActive,
  output logic       readyPulse
);
  seqState_t stateQ, stateNext;
  logic      wakePend;

  always_comb begin
    stateNext = stateQ;
    stb       = '0;
    case (stateQ)
      ST_ACTIVE: if (sleepCmd) begin
        stateNext   = ST_OFF_HOLD;
        stb.loadOff = 1'b1;
      end
      ST_OFF_HOLD: begin
        stb.countFast = 1'b1;
        if (tmrZero) begin
          if (wakePend || wakeEvt) begin
            stateNext    = ST_RAIL_WAIT;
            stb.loadRail = 1'b1;
          end else begin
            stateNext = ST_OFF_WAIT;
          end
        end
      end
      ST_OFF_WAIT: if (wakeEvt) begin
        stateNext    = ST_RAIL_WAIT;
        stb.loadRail = 1'b1;
      end
      ST_RAIL_WAIT: begin
        stb.countFast = 1'b1;
        if (tmrZero) begin
          stateNext   = ST_OSC_WAIT;
          stb.loadOsc = 1'b1;
        end
      end
      ST_OSC_WAIT: begin
        stb.countSlow = 1'b1;
        if (tmrZero) stateNext = ST_ACTIVE;
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_ACTIVE;
      wakePend   <= 1'b0;
      readyPulse <= 1'b0;
    end else begin
      stateQ     <= stateNext;
      readyPulse <= (stateQ == ST_OSC_WAIT) && (stateNext == ST_ACTIVE);
      if (stateQ == ST_OFF_HOLD) wakePend <= wakePend || wakeEvt;
      else                       wakePend <= 1'b0;
    end
  end

  assign reqActive = (stateQ != ST_OFF_HOLD) && (stateQ != ST_OFF_WAIT);

  a_r8_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |=> !readyPulse);
  a_r5_hold_min_off: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OFF_HOLD && !tmrZero) |=> (stateQ == ST_OFF_HOLD));
  a_r6_latched_wake: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OFF_HOLD && tmrZero && wakePend) |=> (stateQ == ST_RAIL_WAIT));
  a_r7_osc_after_rail: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OSC_WAIT && $past(stateQ) != ST_OSC_WAIT) |-> ($past(stateQ) == ST_RAIL_WAIT));
  a_r10_no_resleep: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RAIL_WAIT && sleepCmd && !tmrZero) |=> (stateQ == ST_RAIL_WAIT));
endmodule

// File: rtl/deep_sleep_seq.sv
module deep_sleep_seq
  import dss_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int SLOW_DIV = 4,
  parameter int DATA_W   = 16,
  parameter int OFF_W    = 16,
  parameter int RAIL_DEF = 4,
  parameter int OSC_DEF  = 2,
  parameter int OFF_DEF  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regData,
  input  logic              wakeEvt,
  output logic              coreReq,
  output logic              clkReq,
  output logic              clkReqOe,
  output logic              ready
);
  logic       fastTick, slowTick, sleepCmd, tmrZero, reqActive;
  seqStrobe_t stb;

  dss_tick #(.PRESCALE(PRESCALE), .SLOW_DIV(SLOW_DIV)) uTick (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .slowTick(slowTick));

  dss_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sleepCmd(sleepCmd), .wakeEvt(wakeEvt),
    .tmrZero(tmrZero), .stb(stb), .reqActive(reqActive), .readyPulse(ready));

  dss_dpath #(.DATA_W(DATA_W), .OFF_W(OFF_W), .RAIL_DEF(RAIL_DEF),
              .OSC_DEF(OSC_DEF), .OFF_DEF(OFF_DEF)) uDpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .stb(stb), .fastTick(fastTick), .slowTick(slowTick), .reqActive(reqActive),
    .sleepCmd(sleepCmd), .tmrZero(tmrZero), .coreReqPin(coreReq),
    .clkReqPin(clkReq), .clkReqOe(clkReqOe));
endmodule

// File: tb/deep_sleep_seq_test.sv
module deep_sleep_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 4;
  localparam int SLOW = 4 * TICK;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [15:0] regData = '0;
  logic wakeEvt = 1'b0;
  logic coreReq, clkReq, clkReqOe, ready;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic coreInv = 1'b0;

  deep_sleep_seq uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .wakeEvt(wakeEvt), .coreReq(coreReq), .clkReq(clkReq), .clkReqOe(clkReqOe),
    .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
    end
  endtask

  function automatic int offLo(int n);  return (n - 1) * TICK + 1; endfunction
  function automatic int offHi(int n);  return n * TICK + 2;       endfunction
  function automatic int exitLo(int r, int o); return (r - 1) * TICK + (o - 1) * SLOW; endfunction
  function automatic int exitHi(int r, int o); return r * TICK + o * SLOW + 3;         endfunction

  task automatic writeReg(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWe = 1'b0; regData = '0;
  endtask

  task automatic pulseWake();
    wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
  endtask

  // One full sleep/wake round with expected durations
  task automatic sleepRound(int offT, int rail, int osc, bit early, bit resleep);
    int n, m;
    writeReg(2'd3, 16'h0001);
    check("R4 request dropped after sleep", int'(coreReq), int'(coreInv));
    n = 0;
    if (early) begin
      while ((coreReq ^ coreInv) == 1'b0 && n < 5000) begin
        n++;
        wakeEvt = (n == 1);
        @(negedge clk);
      end
      wakeEvt = 1'b0;
      checkRange("R5 min off time with early wake", n, offLo(offT), offHi(offT));
    end else begin
      while (n < offT * TICK + 6) begin
        if ((coreReq ^ coreInv) != 1'b0) break;
        n++;
        @(negedge clk);
      end
      check("R6 stays asleep without wake", int'(coreReq ^ coreInv), 0);
      pulseWake();
      check("R6 exit right after late wake", int'(coreReq ^ coreInv), 1);
    end
    check("R2 active level on exit", int'(coreReq), int'(!coreInv));
    m = 0;
    if (resleep) begin
      writeReg(2'd3, 16'h0001);
      m = 2;
      check("R10 sleep ignored during exit", int'(coreReq ^ coreInv), 1);
    end
    while (ready !== 1'b1 && m < 5000) begin
      @(negedge clk);
      m++;
    end
    checkRange("R7 chained rail then osc wait", m, exitLo(rail, osc), exitHi(rail, osc) + (resleep ? 2 : 0));
    @(negedge clk);
    check("R8 ready single cycle", int'(ready), 0);
    check("R10 still awake after ignored sleep", int'(coreReq ^ coreInv), 1);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(1234);
    repeat (3) @(negedge clk);
    check("R1 core request active high after reset", int'(coreReq), 1);
    check("R1 clock request low after reset", int'(clkReq), 0);
    check("R1 clock oe low after reset", int'(clkReqOe), 0);
    check("R1 ready low after reset", int'(ready), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Defaults: off 8, rail 4, osc 2
    sleepRound(8, 4, 2, 1'b1, 1'b0);

    // R3 clock request enable and polarity
    writeReg(2'd0, 16'h0004);
    check("R3 oe follows bit 2", int'(clkReqOe), 1);
    check("R3 clock request active high", int'(clkReq), 1);
    writeReg(2'd0, 16'h0006);
    check("R3 clock request active low", int'(clkReq), 0);
    writeReg(2'd3, 16'h0001);
    check("R3 clock request inactive low-polarity", int'(clkReq), 1);
    pulseWake();
    while (ready !== 1'b1 && cycles < 100000) @(negedge clk);
    @(negedge clk);

    // R2 active-low core request
    writeReg(2'd0, 16'h0001);
    coreInv = 1'b1;
    check("R2 active low while awake", int'(coreReq), 0);
    writeReg(2'd1, 16'h0102);
    writeReg(2'd2, 16'd5);
    sleepRound(5, 2, 1, 1'b1, 1'b0);

    // R9 zero writes ignored
    writeReg(2'd2, 16'd0);
    writeReg(2'd1, 16'h0032);
    writeReg(2'd1, 16'h3200);
    sleepRound(5, 2, 1, 1'b1, 1'b0);
    writeReg(2'd0, 16'h0000);
    coreInv = 1'b0;

    // Random rounds
    for (int i = 0; i < 10; i++) begin
      int offT, rail, osc;
      bit early, rs;
      offT  = 2 + int'($urandom_range(0, 30));
      rail  = 1 + int'($urandom_range(0, 9));
      osc   = 1 + int'($urandom_range(0, 4));
      early = $urandom_range(0, 1) == 1;
      rs    = (i % 4) == 3;
      writeReg(2'd2, 16'(offT));
      writeReg(2'd1, {8'(osc), 8'(rail)});
      sleepRound(offT, rail, osc, early, rs);
    end

    // Directed: minimum off time with long rail, late wake
    writeReg(2'd2, 16'd1);
    writeReg(2'd1, 16'h010C);
    sleepRound(1, 12, 1, 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule